// File: doc/BRIEF.md
# Card Clock Divider with Glitch-Free Ratio Switching

This block produces the clock driven to a smart card contact. Its input clock `clk` is a timebase at twice the reference rate: one reference period equals two `clk` cycles. The card clock is a square wave whose period is 1, 2, 4 or 8 reference periods, chosen by a 2-bit select. The code points follow a Gray order, so a legal change of the select flips one bit at a time.

A change of ratio is never applied in the middle of a pulse. The current low phase runs to its end, and the new ratio starts with the next rising edge. As a result, the pulse before the change and the pulse after it both have full width.

A gate input from the activation sequencer starts the clock and stops it. When the gate drops, the current pulse finishes and the output then parks low. When the gate returns, the output rises on the next clock edge with a full-width high phase. A one-cycle strobe marks the edge at which a new ratio has taken effect.

Top module: `card_clk_div`

## Requirements
- R1: The select code sets the length of each half period in `clk` cycles: 2'b10 gives 1 (card clock equal to the reference), 2'b11 gives 2, 2'b01 gives 4 and 2'b00 gives 8.
- R2: While `rst_n` is low, `card_clk` and `sel_done` are low and the ratio in force is code 2'b00. With `gate_en` high, the first clock edge after reset is released drives `card_clk` high.
- R3: A select value held steady takes effect, marked by `sel_done`, no later than the 16th rising `clk` edge after it is first sampled. This is eight reference periods.
- R4: A ratio change is applied only where a low phase ends. Every high phase has the full half length of the ratio in force, and the low phase before a change keeps the full half length of the old ratio.
- R5: While the gate stays high, each low phase equals the half length of the ratio that produced it, which gives a 50% duty cycle.
- R6: While `gate_en` is sampled low, `card_clk` never rises. A high phase in progress completes at full width, and the output then stays low.
- R7: When `gate_en` returns high with the clock parked, `card_clk` rises on the next edge and holds high for the full half length.
- R8: `sel_done` is a one-cycle pulse on the edge at which a different code is adopted. With the gate high, this is the same edge on which `card_clk` rises. Holding the select at the code already in force gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase at twice the reference rate |
| rst_n | input | 1 | Active-low synchronous reset |
| div_sel | input | 2 | Ratio select code, Gray ordered |
| gate_en | input | 1 | Sequencer gate: high runs the card clock, low parks it low |
| card_clk | output | 1 | Divided card clock |
| sel_done | output | 1 | One-cycle strobe when a new ratio takes effect |

## Verification
A wrong phase counter shows at the next edge of `card_clk` as a high or low phase of the wrong length. A wrong switchover point shows as a short or stretched pulse next to the `sel_done` strobe. A lost pending ratio shows as a missing strobe within 16 cycles of the select change. A gate that is not honoured shows as a rising edge while the gate is low, or as a stopped clock that does not restart on the edge after the gate returns.

// File: rtl/ccd_pkg.sv
package ccd_pkg;

    localparam int SEL_W   = 2;
    localparam int LOG_MAX = 3;
    localparam int CNT_W   = LOG_MAX;
    localparam int HALF_W  = LOG_MAX + 1;

    typedef enum logic [SEL_W-1:0] {
        SEL_DIV8 = 2'b00,
        SEL_DIV4 = 2'b01,
        SEL_DIV1 = 2'b10,
        SEL_DIV2 = 2'b11
    } ccd_sel_e;

    // log2 of the half-period length for a select code
    function automatic logic [1:0] sel_log(input logic [SEL_W-1:0] code);
        case (code)
            SEL_DIV1: sel_log = 2'd0;
            SEL_DIV2: sel_log = 2'd1;
            SEL_DIV4: sel_log = 2'd2;
            default:  sel_log = 2'd3;
        endcase
    endfunction

    function automatic logic [HALF_W-1:0] half_len(input logic [SEL_W-1:0] code);
        half_len = HALF_W'(1) << sel_log(code);
    endfunction

    typedef struct packed {
        logic             out;
        logic             idle;
        logic             done;
        logic [SEL_W-1:0] act;
        logic [CNT_W-1:0] cnt;
    } ccd_state_t;

endpackage

// File: rtl/ccd_ratio_dec.sv
module ccd_ratio_dec
    import ccd_pkg::*;
(
    input  logic [SEL_W-1:0] code,
    output logic [CNT_W-1:0] half_m1
);

    logic [HALF_W-1:0] half_full;

    always_comb begin
        half_full = half_len(code);
        half_m1   = CNT_W'(half_full - HALF_W'(1));
    end

endmodule

// File: rtl/ccd_phase.sv
module ccd_phase
    import ccd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gate_en,
    input  logic [SEL_W-1:0] div_sel,
    input  logic [CNT_W-1:0] half_m1,
    output logic             out_clk,
    output logic             done,
    output logic [SEL_W-1:0] act_code
);

    ccd_state_t s_d, s_q;
    logic       at_end;
    logic       rise_pt;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        at_end   = (s_q.cnt == half_m1);
        rise_pt  = !s_q.out && (s_q.idle || at_end);
        if (rise_pt) begin
            // end of a low phase: the only point where the ratio may change
            if (div_sel != s_q.act) begin
                s_d.act  = div_sel;
                s_d.done = 1'b1;
            end
            s_d.cnt  = '0;
            s_d.out  = gate_en;
            s_d.idle = !gate_en;
        end else if (s_q.out && at_end) begin
            s_d.out = 1'b0;
            s_d.cnt = '0;
        end else begin
            s_d.cnt = s_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.out  <= 1'b0;
            s_q.idle <= 1'b1;
            s_q.done <= 1'b0;
            s_q.act  <= SEL_DIV8;
            s_q.cnt  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign out_clk  = s_q.out;
    assign done     = s_q.done;
    assign act_code = s_q.act;

endmodule

// File: rtl/card_clk_div.sv
module card_clk_div
    import ccd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] div_sel,
    input  logic             gate_en,
    output logic             card_clk,
    output logic             sel_done
);

    logic [SEL_W-1:0] act_code;
    logic [CNT_W-1:0] half_m1;

    ccd_ratio_dec i_dec (
        .code    (act_code),
        .half_m1 (half_m1)
    );

    ccd_phase i_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .gate_en  (gate_en),
        .div_sel  (div_sel),
        .half_m1  (half_m1),
        .out_clk  (card_clk),
        .done     (sel_done),
        .act_code (act_code)
    );

endmodule

// File: rtl/ccd_checker.sv
module ccd_checker
    import ccd_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             gate_en,
    input logic [SEL_W-1:0] div_sel,
    input logic             card_clk,
    input logic             sel_done,
    input logic [SEL_W-1:0] act_code
);

    localparam int WIN = 2 * (1 << LOG_MAX);

    logic [5:0]       hi_q;
    logic [5:0]       pend_q;
    logic [SEL_W-1:0] prev_sel_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q       <= '0;
            pend_q     <= '0;
            prev_sel_q <= SEL_DIV8;
        end else begin
            prev_sel_q <= div_sel;
            if (card_clk && hi_q != 6'h3f) hi_q <= hi_q + 6'd1;
            else if (!card_clk)            hi_q <= '0;
            if (div_sel == act_code)        pend_q <= '0;
            else if (div_sel != prev_sel_q) pend_q <= 6'd1;
            else if (pend_q != 6'h3f)       pend_q <= pend_q + 6'd1;
        end
    end

    // R6: no rising edge while the gate is low
    p_hold_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_en && !card_clk) |=> !card_clk);

    // R4: each high phase lasts the full half length of the ratio in force
    p_full_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(card_clk) |-> (hi_q == 6'(half_len(act_code))));

    // R4: the ratio never changes inside a high phase
    p_act_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (card_clk && $past(card_clk)) |-> $stable(act_code));

    // R3: a steady select is adopted within the window
    p_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q <= 6'(WIN));

    // R8: the strobe marks an actual change of ratio
    p_done_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sel_done |-> (act_code != $past(act_code)));

endmodule

bind card_clk_div ccd_checker i_ccd_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .gate_en  (gate_en),
    .div_sel  (div_sel),
    .card_clk (card_clk),
    .sel_done (sel_done),
    .act_code (act_code)
);

// File: tb/test_card_clk_div.sv
module test_card_clk_div;

    localparam int CLK_PERIOD = 10;
    localparam int WINDOW     = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] div_sel = 2'b00;
    logic       gate_en = 1'b1;
    logic       card_clk;
    logic       sel_done;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // bench monitor state
    logic [1:0] exp_code = 2'b00;
    logic       prev_clk = 1'b0;
    int         run_len = 0;
    bit         low_ok = 1'b0;
    int         chg_cyc = 0;
    int         pend = 0;
    int         done_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    card_clk_div i_card_clk_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .div_sel  (div_sel),
        .gate_en  (gate_en),
        .card_clk (card_clk),
        .sel_done (sel_done)
    );

    function automatic int exp_half(input logic [1:0] code);
        case (code)
            2'b10:   return 1;
            2'b11:   return 2;
            2'b01:   return 4;
            default: return 8;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    task automatic monitor();
        logic cur;
        cur = card_clk;
        if (cur != prev_clk) begin
            if (prev_clk) begin
                chk(run_len == exp_half(exp_code), "R4 high width", run_len, exp_half(exp_code));
            end else begin
                chk(gate_en, "R6 rise with gate low", 1, 0);
                if (low_ok)
                    chk(run_len == exp_half(exp_code), "R5 low width", run_len, exp_half(exp_code));
            end
            run_len = 1;
            low_ok  = 1'b1;
        end else begin
            run_len++;
        end
        if (!gate_en) low_ok = 1'b0;
        if (sel_done) begin
            done_cnt++;
            if (gate_en) chk(cur && !prev_clk, "R8 strobe on rise", int'(cur), 1);
            chk(div_sel != exp_code, "R8 strobe without change", int'(div_sel), int'(exp_code));
            chk(cyc - chg_cyc <= WINDOW, "R3 latency", cyc - chg_cyc, WINDOW);
            exp_code = div_sel;
            pend = 0;
        end else if (div_sel != exp_code) begin
            pend++;
            if (pend > WINDOW) begin
                chk(1'b0, "R3 not adopted", pend, WINDOW);
                pend = 0;
            end
        end
        prev_clk = cur;
    endtask

    task automatic tick();
        @(negedge clk);
        cyc++;
        monitor();
    endtask

    task automatic set_sel(input logic [1:0] code);
        if (code[0] != div_sel[0] && code[1] != div_sel[1]) begin
            div_sel[0] = code[0];
            chg_cyc = cyc; pend = 0;
            tick();
        end
        if (code != div_sel) begin
            div_sel = code;
            chg_cyc = cyc; pend = 0;
        end
    endtask

    task automatic wait_rise();
        for (int i = 0; i < 40; i++) begin
            tick();
            if (card_clk && run_len == 1) return;
        end
    endtask

    initial begin
        int p;
        repeat (3) @(negedge clk);
        chk(card_clk == 1'b0, "R2 reset clock", int'(card_clk), 0);
        chk(sel_done == 1'b0, "R2 reset strobe", int'(sel_done), 0);
        rst_n = 1'b1;
        tick();
        chk(card_clk == 1'b1, "R2 first rise", int'(card_clk), 1);
        repeat (40) tick();

        // R1: period per code
        foreach (p_codes[k]) begin
            set_sel(p_codes[k]);
            repeat (40) tick();
            wait_rise();
            p = 0;
            do begin tick(); p++; end while (!(card_clk && run_len == 1) && p < 40);
            chk(p == 2 * exp_half(p_codes[k]), "R1 period", p, 2 * exp_half(p_codes[k]));
        end

        // R8: unchanged select gives no strobe
        p = done_cnt;
        set_sel(div_sel);
        repeat (30) tick();
        chk(done_cnt == p, "R8 no strobe when unchanged", done_cnt - p, 0);

        // R6 and R7: park and restart
        set_sel(2'b00);
        repeat (20) tick();
        wait_rise();
        tick();
        gate_en = 1'b0;
        repeat (30) tick();
        chk(card_clk == 1'b0, "R6 parked low", int'(card_clk), 0);
        gate_en = 1'b1;
        tick();
        chk(card_clk == 1'b1, "R7 restart edge", int'(card_clk), 1);
        repeat (20) tick();

        // random ratio changes and gate toggles
        for (int n = 0; n < 60; n++) begin
            set_sel(2'($urandom));
            if ($urandom_range(0, 7) == 0) gate_en = ~gate_en;
            repeat ($urandom_range(0, 40)) tick();
        end
        gate_en = 1'b1;
        repeat (40) tick();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    logic [1:0] p_codes [4] = '{2'b10, 2'b11, 2'b01, 2'b00};

    initial begin
        void'($urandom(32'd7715));
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog at cycle %0d: actual %0d expected %0d", cyc, 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule